// File: doc/BRIEF.md
# Programmable Multichannel Serial Audio Receiver

This block receives a time-division serial audio stream as a slave to an external bit clock and frame clock. The clock, frame and data pins are brought into the system clock domain through synchronizers. The block finds the edges of the bit clock, locates the frame start and counts bits into slots. From each frame it assembles two audio words, each taken from a slot chosen by configuration. Both words come out together with a single valid pulse when the frame ends.

The format is set on static configuration inputs. These choose the sampling edge for the frame clock and for the data, the frame clock polarity, and an option that marks the frame start one bit period early. They also set the bit order, the number of channels and the slot width, and the leading pad count and audio resolution inside a slot. If a frame start arrives after an unexpected number of bits, the block flags a sync error and realigns to the new start. The configuration must only change while reset is held. The settings must satisfy `cfg_pad + cfg_res <= cfg_slot_bits`.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is held and after its release, until the first frame completes, `samp_a`, `samp_b`, `samp_valid` and `sync_err` are all zero.
- R2: `cfg_fs_fall` = 0 samples the frame clock on the rising bit-clock edge; 1 samples it on the falling edge.
- R3: `cfg_sd_fall` = 0 samples the data on the rising bit-clock edge; 1 samples it on the falling edge. This choice is independent of R2.
- R4: The active frame level is high when `cfg_fs_inv` = 0 and low when it is 1. A frame start is an active frame sample that follows an inactive one. Without the early option, the first data sample taken at or after that frame sample is bit 0 of slot 0.
- R5: With `cfg_fs_early` = 1, the first data sample taken at or after the frame detection is the final bit of the previous frame. The data sample after it is bit 0 of slot 0.
- R6: Within a slot, bit positions `cfg_pad` up to `cfg_pad+cfg_res-1` carry the audio word and all other positions are discarded. The word is returned right-aligned in bits `cfg_res-1:0`, with the upper bits zero.
- R7: `cfg_msb_first` = 1 takes the first word bit as the MSB. With 0, the first word bit is bit 0.
- R8: A right-justified word is received by setting `cfg_pad` = `cfg_slot_bits - cfg_res`.
- R9: Slots are numbered from 0 at the frame start. `samp_a` holds the word of slot `cfg_slot_a` and `samp_b` holds the word of slot `cfg_slot_b`. A slot number at or above `cfg_chans` yields zero.
- R10: `cfg_chans` takes the values 1 to 256 and `cfg_slot_bits` takes 1 to 32. A frame lasts `cfg_chans*cfg_slot_bits` data samples. Without a new frame start, the count wraps and continues.
- R11: Both outputs update on the same cycle, marked by a one-cycle `samp_valid` pulse. The pulse comes three system clocks after the bit-clock pin edge that carries the last bit of the frame. No pulse occurs before the first frame start, and the outputs hold at all other times.
- R12: Once locked, a frame start after a number of data samples other than `cfg_chans*cfg_slot_bits` raises `sync_err` for one cycle, aligned as in R11. The count realigns to the new start, and an interrupted frame gives no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame clock |
| sdata_in | input | 1 | Serial data |
| cfg_fs_fall | input | 1 | Frame clock sampling edge, 1 = falling |
| cfg_sd_fall | input | 1 | Data sampling edge, 1 = falling |
| cfg_fs_inv | input | 1 | 1 = frame clock active low |
| cfg_fs_early | input | 1 | 1 = frame start marked one bit early |
| cfg_msb_first | input | 1 | 1 = word arrives MSB first |
| cfg_chans | input | 9 | Channels per frame, 1..256 |
| cfg_slot_bits | input | 6 | Bits per slot, 1..32 |
| cfg_res | input | 6 | Audio word resolution, 1..32 |
| cfg_pad | input | 6 | Leading pad bits in a slot |
| cfg_slot_a | input | 9 | Slot for output A |
| cfg_slot_b | input | 9 | Slot for output B |
| samp_a | output | 32 | Word from slot A, right-aligned |
| samp_b | output | 32 | Word from slot B, right-aligned |
| samp_valid | output | 1 | One-cycle pulse when both words update |
| sync_err | output | 1 | One-cycle frame length mismatch flag |

## Verification
The stream is tried with several formats:
- A two-channel layout with a one-bit-early, active-low frame clock.
- An eight-slot LSB-first stream whose frame and data clocks use opposite edges.
- A right-justified word with twelve leading pad bits.
- A single-channel frame with the second slot absent.
- A 256-channel frame with two-bit slots.

Across these formats, a swapped bit order, a slot off by one or an edge choice that is ignored all change the captured words. Pad bits are sent as ones, so any pad bit that leaks into a word shows up as a wrong value. One run stretches one frame by a bit and cuts another short by three bits. This run separates a correct realignment from a receiver that keeps counting or still reports the broken frame.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_FIRST = 2'd1,
    PEND_SKIP  = 2'd2
  } pend_e;

  // Position inside the output word of the k-th transmitted word bit.
  function automatic int word_slot_index(int k, int res, logic msb_first);
    return msb_first ? (res - 1 - k) : k;
  endfunction

  // Number of data samples in one frame.
  function automatic int frame_bit_total(int chans, int slot_bits);
    return chans * slot_bits;
  endfunction

endpackage

// File: rtl/tdmrx_front.sv
module tdmrx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic fs_pin,
  input  logic sd_pin,
  input  logic cfg_fs_fall,
  input  logic cfg_sd_fall,
  output logic fs_tick,
  output logic sd_tick,
  output logic fs_lvl,
  output logic sd_lvl
);
  logic [SYNC_STAGES-1:0] sclk_sr, fs_sr, sd_sr;
  logic sclk_prev_q;
  logic sclk_rise, sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr     <= '0;
      fs_sr       <= '0;
      sd_sr       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_sr     <= {sclk_sr[SYNC_STAGES-2:0], sclk_pin};
      fs_sr       <= {fs_sr[SYNC_STAGES-2:0], fs_pin};
      sd_sr       <= {sd_sr[SYNC_STAGES-2:0], sd_pin};
      sclk_prev_q <= sclk_sr[SYNC_STAGES-1];
    end
  end

  assign sclk_rise = sclk_sr[SYNC_STAGES-1] & ~sclk_prev_q;
  assign sclk_fall = ~sclk_sr[SYNC_STAGES-1] & sclk_prev_q;
  assign fs_tick   = cfg_fs_fall ? sclk_fall : sclk_rise;
  assign sd_tick   = cfg_sd_fall ? sclk_fall : sclk_rise;
  assign fs_lvl    = fs_sr[SYNC_STAGES-1];
  assign sd_lvl    = sd_sr[SYNC_STAGES-1];

  // R3
  sd_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_tick |=> !sd_tick);

endmodule

// File: rtl/tdmrx_framer.sv
module tdmrx_framer #(
  parameter int CH_W  = 9,
  parameter int SB_W  = 6,
  parameter int LEN_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_tick,
  input  logic            fs_lvl,
  input  logic            sd_tick,
  input  logic            cfg_fs_inv,
  input  logic            cfg_fs_early,
  input  logic [CH_W-1:0] cfg_chans,
  input  logic [SB_W-1:0] cfg_slot_bits,
  output logic            bit_stb,
  output logic            word_first,
  output logic            frame_end,
  output logic [CH_W-1:0] cur_slot,
  output logic [SB_W-1:0] cur_bit,
  output logic            sync_err
);
  import tdmrx_pkg::*;

  pend_e            pend_q, eff_pend;
  logic             fs_last_q, locked_q, err_q;
  logic [SB_W-1:0]  nb_q;
  logic [CH_W-1:0]  ns_q;
  logic [LEN_W-1:0] len_q, total_bits;
  logic             fs_act, fs_start_seen, frame_start, bit_adv;
  logic             last_in_slot, last_slot, len_mismatch;

  assign total_bits    = LEN_W'(frame_bit_total(int'(cfg_chans), int'(cfg_slot_bits)));
  assign fs_act        = fs_lvl ^ cfg_fs_inv;
  assign fs_start_seen = fs_tick & fs_act & ~fs_last_q;
  assign eff_pend      = fs_start_seen ? (cfg_fs_early ? PEND_SKIP : PEND_FIRST) : pend_q;
  assign frame_start   = sd_tick && (eff_pend == PEND_FIRST);
  assign bit_adv       = sd_tick && locked_q && !frame_start;
  assign bit_stb       = frame_start | bit_adv;
  assign cur_bit       = frame_start ? '0 : nb_q;
  assign cur_slot      = frame_start ? '0 : ns_q;
  assign last_in_slot  = (cur_bit == cfg_slot_bits - SB_W'(1));
  assign last_slot     = (cur_slot == cfg_chans - CH_W'(1));
  assign frame_end     = bit_stb & last_in_slot & last_slot;
  assign word_first    = bit_stb & (cur_bit == '0) & (cur_slot == '0);
  assign len_mismatch  = frame_start & locked_q & (len_q != total_bits);
  assign sync_err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= PEND_NONE;
      fs_last_q <= 1'b1;
      locked_q  <= 1'b0;
      err_q     <= 1'b0;
      nb_q      <= '0;
      ns_q      <= '0;
      len_q     <= '0;
    end else begin
      if (fs_tick) fs_last_q <= fs_act;
      if (sd_tick) pend_q <= (eff_pend == PEND_SKIP) ? PEND_FIRST : PEND_NONE;
      else         pend_q <= eff_pend;
      if (bit_stb) begin
        nb_q <= last_in_slot ? '0 : cur_bit + SB_W'(1);
        ns_q <= last_in_slot ? (last_slot ? '0 : cur_slot + CH_W'(1)) : cur_slot;
      end
      if (frame_start)                 len_q <= LEN_W'(1);
      else if (bit_adv && ~&len_q)     len_q <= len_q + LEN_W'(1);
      locked_q <= locked_q | frame_start;
      err_q    <= len_mismatch;
    end
  end

  // R12
  err_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> locked_q);

  // R12
  realign_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (len_q == LEN_W'(1)));

  // R10
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (nb_q < cfg_slot_bits));

endmodule

// File: rtl/tdmrx_capture.sv
module tdmrx_capture #(
  parameter int WORD_W = 32,
  parameter int CH_W   = 9,
  parameter int SB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              word_first,
  input  logic              frame_end,
  input  logic [CH_W-1:0]   cur_slot,
  input  logic [SB_W-1:0]   cur_bit,
  input  logic              sd_lvl,
  input  logic [SB_W-1:0]   cfg_pad,
  input  logic [SB_W-1:0]   cfg_res,
  input  logic              cfg_msb,
  input  logic [CH_W-1:0]   cfg_slot_a,
  input  logic [CH_W-1:0]   cfg_slot_b,
  output logic [WORD_W-1:0] samp_a,
  output logic [WORD_W-1:0] samp_b,
  output logic              samp_valid
);
  import tdmrx_pkg::*;
  localparam int IDX_W = $clog2(WORD_W);
  localparam int LANES = 2;

  logic                        in_word;
  logic [SB_W-1:0]             k_pos;
  logic [IDX_W-1:0]            idx;
  logic [LANES-1:0][WORD_W-1:0] lane_out;
  logic                        valid_q;

  assign in_word = ({1'b0, cur_bit} >= {1'b0, cfg_pad}) &&
                   ({1'b0, cur_bit} < ({1'b0, cfg_pad} + {1'b0, cfg_res}));
  assign k_pos   = cur_bit - cfg_pad;
  assign idx     = IDX_W'(word_slot_index(int'(k_pos), int'(cfg_res), cfg_msb));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CH_W-1:0]   sel_slot;
    logic [WORD_W-1:0] acc_q, acc_nx, out_q;

    assign sel_slot = (g == 0) ? cfg_slot_a : cfg_slot_b;

    always_comb begin
      acc_nx = word_first ? '0 : acc_q;
      if (bit_stb && in_word && (cur_slot == sel_slot)) acc_nx[idx] = sd_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        out_q <= '0;
      end else begin
        if (bit_stb)   acc_q <= acc_nx;
        if (frame_end) out_q <= acc_nx;
      end
    end

    assign lane_out[g] = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= frame_end;
  end

  assign samp_a     = lane_out[0];
  assign samp_b     = lane_out[1];
  assign samp_valid = valid_q;

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |=> !samp_valid);

  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |-> ($stable(samp_a) && $stable(samp_b)));

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
  parameter int MAX_CHANS     = 256,
  parameter int MAX_SLOT_BITS = 32,
  parameter int SYNC_STAGES   = 2,
  localparam int CH_W   = $clog2(MAX_CHANS + 1),
  localparam int SB_W   = $clog2(MAX_SLOT_BITS + 1),
  localparam int WORD_W = MAX_SLOT_BITS,
  localparam int LEN_W  = $clog2(MAX_CHANS * MAX_SLOT_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  input  logic              cfg_fs_fall,
  input  logic              cfg_sd_fall,
  input  logic              cfg_fs_inv,
  input  logic              cfg_fs_early,
  input  logic              cfg_msb_first,
  input  logic [CH_W-1:0]   cfg_chans,
  input  logic [SB_W-1:0]   cfg_slot_bits,
  input  logic [SB_W-1:0]   cfg_res,
  input  logic [SB_W-1:0]   cfg_pad,
  input  logic [CH_W-1:0]   cfg_slot_a,
  input  logic [CH_W-1:0]   cfg_slot_b,
  output logic [WORD_W-1:0] samp_a,
  output logic [WORD_W-1:0] samp_b,
  output logic              samp_valid,
  output logic              sync_err
);
  logic            fs_tick, sd_tick, fs_lvl, sd_lvl;
  logic            bit_stb, word_first, frame_end;
  logic [CH_W-1:0] cur_slot;
  logic [SB_W-1:0] cur_bit;

  tdmrx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .sclk_pin(sclk_in), .fs_pin(fsync_in), .sd_pin(sdata_in),
    .cfg_fs_fall(cfg_fs_fall), .cfg_sd_fall(cfg_sd_fall),
    .fs_tick(fs_tick), .sd_tick(sd_tick), .fs_lvl(fs_lvl), .sd_lvl(sd_lvl)
  );

  tdmrx_framer #(.CH_W(CH_W), .SB_W(SB_W), .LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .fs_tick(fs_tick), .fs_lvl(fs_lvl), .sd_tick(sd_tick),
    .cfg_fs_inv(cfg_fs_inv), .cfg_fs_early(cfg_fs_early),
    .cfg_chans(cfg_chans), .cfg_slot_bits(cfg_slot_bits),
    .bit_stb(bit_stb), .word_first(word_first), .frame_end(frame_end),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .sync_err(sync_err)
  );

  tdmrx_capture #(.WORD_W(WORD_W), .CH_W(CH_W), .SB_W(SB_W)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .word_first(word_first), .frame_end(frame_end),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .sd_lvl(sd_lvl),
    .cfg_pad(cfg_pad), .cfg_res(cfg_res), .cfg_msb(cfg_msb_first),
    .cfg_slot_a(cfg_slot_a), .cfg_slot_b(cfg_slot_b),
    .samp_a(samp_a), .samp_b(samp_b), .samp_valid(samp_valid)
  );

endmodule

// File: tb/sim_tdm_frame_rx.sv
module sim_tdm_frame_rx;
  localparam int CH_W = 9, SB_W = 6, WORD_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, fs_pin = 1'b0, sd_pin = 1'b0;
  logic fs_fall = 0, sd_fall = 0, fs_inv = 0, fs_early = 0, msb = 1;
  logic [CH_W-1:0] chans = 2, slot_a = 0, slot_b = 1;
  logic [SB_W-1:0] sbits = 16, res = 16, pad = 0;
  logic [WORD_W-1:0] samp_a, samp_b;
  logic samp_valid, sync_err;

  always #4 clk = ~clk;

  tdm_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fsync_in(fs_pin), .sdata_in(sd_pin),
    .cfg_fs_fall(fs_fall), .cfg_sd_fall(sd_fall), .cfg_fs_inv(fs_inv),
    .cfg_fs_early(fs_early), .cfg_msb_first(msb), .cfg_chans(chans),
    .cfg_slot_bits(sbits), .cfg_res(res), .cfg_pad(pad),
    .cfg_slot_a(slot_a), .cfg_slot_b(slot_b),
    .samp_a(samp_a), .samp_b(samp_b), .samp_valid(samp_valid), .sync_err(sync_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_err = 0;
  string tag = "R1";
  bit checking = 0;

  typedef struct { int due; logic [31:0] a; logic [31:0] b; } vev_t;
  vev_t vq[$];
  int   eq[$];

  // behavioural reference state
  int m_fs_last, m_pend, m_locked, m_len, m_pos;
  logic [31:0] m_acc_a, m_acc_b;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_fs_last = 1; m_pend = 0; m_locked = 0; m_len = 0; m_pos = 0;
    m_acc_a = 0; m_acc_b = 0;
    vq.delete(); eq.delete();
  endtask

  task automatic take_bit(input logic d);
    int total, slot, b, k, idx;
    total = int'(chans) * int'(sbits);
    if (m_pos == 0) begin m_acc_a = 0; m_acc_b = 0; end
    slot = m_pos / int'(sbits);
    b = m_pos % int'(sbits);
    k = b - int'(pad);
    if (k >= 0 && k < int'(res)) begin
      idx = msb ? int'(res) - 1 - k : k;
      if (slot == int'(slot_a)) m_acc_a[idx] = d;
      if (slot == int'(slot_b)) m_acc_b[idx] = d;
    end
    if (m_pos == total - 1) vq.push_back('{cyc + 3, m_acc_a, m_acc_b});
  endtask

  // called at the moment the bench moves the bit clock pin
  task automatic model_edge(input bit rising);
    int total, eff;
    bit det, act;
    total = int'(chans) * int'(sbits);
    det = 0;
    if (rising == !fs_fall) begin
      act = fs_pin ^ fs_inv;
      det = act && (m_fs_last == 0);
      m_fs_last = act;
    end
    eff = det ? (fs_early ? 2 : 1) : m_pend;
    if (rising == !sd_fall) begin
      if (eff == 1) begin
        if (m_locked != 0 && m_len != total) eq.push_back(cyc + 3);
        m_locked = 1; m_len = 1; m_pos = 0;
        take_bit(sd_pin);
      end else if (m_locked != 0) begin
        if (m_len < 16383) m_len++;
        m_pos = (m_pos + 1) % total;
        take_bit(sd_pin);
      end
      m_pend = (eff == 2) ? 1 : 0;
    end else begin
      m_pend = eff;
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && checking) begin
      bit ev, ee;
      ev = (vq.size() > 0) && (vq[0].due == cyc);
      ee = (eq.size() > 0) && (eq[0] == cyc);
      if (samp_valid) n_valid++;
      if (sync_err) n_err++;
      chk(samp_valid == ev, "R11", "valid strobe", 32'(samp_valid), 32'(ev));
      chk(sync_err == ee, "R12", "sync error", 32'(sync_err), 32'(ee));
      if (ev) begin
        chk(samp_a == vq[0].a, tag, "word A", samp_a, vq[0].a);
        chk(samp_b == vq[0].b, tag, "word B", samp_b, vq[0].b);
        void'(vq.pop_front());
      end
      if (ee) void'(eq.pop_front());
      while (vq.size() > 0 && vq[0].due < cyc) void'(vq.pop_front());
      while (eq.size() > 0 && eq[0] < cyc) void'(eq.pop_front());
    end
  end

  // one bit window: the first edge is the frame-clock edge, the second the other one
  task automatic put_bit(input logic d, input logic f);
    sd_pin = d; fs_pin = f;
    repeat (2) @(negedge clk);
    sclk = ~sclk; model_edge(sclk);
    repeat (4) @(negedge clk);
    sclk = ~sclk; model_edge(sclk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] wmask(input int r);
    return (r >= 32) ? 32'hFFFF_FFFF : ((32'd1 << r) - 32'd1);
  endfunction

  function automatic logic [31:0] word_of(input int f, input int s);
    return ((32'h9E37_79B9 * 32'(f + 1)) ^ (32'h0100_0193 * 32'(s + 3)) ^ 32'h5A5A_0F0F)
           & wmask(int'(res));
  endfunction

  task automatic run_scn(input string t, input int ch, input int sb, input int r, input int pd,
                         input bit m, input bit ff, input bit df, input bit inv, input bit erl,
                         input int sa, input int sbb, input int nfr, input int extra_at,
                         input int cut_at, input int exp_valid, input int exp_err);
    int total, half;
    logic [31:0] int_a, int_b;
    tag = t;
    checking = 0;
    @(negedge clk);
    rst_n = 0;
    chans = CH_W'(ch); sbits = SB_W'(sb); res = SB_W'(r); pad = SB_W'(pd);
    msb = m; fs_fall = ff; sd_fall = df; fs_inv = inv; fs_early = erl;
    slot_a = CH_W'(sa); slot_b = CH_W'(sbb);
    sclk = ff ? 1'b1 : 1'b0;
    fs_pin = inv; sd_pin = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    model_reset();
    n_valid = 0; n_err = 0;
    repeat (4) @(negedge clk);
    checking = 1;
    total = ch * sb;
    half = (total / 2 > 0) ? total / 2 : 1;
    for (int i = 0; i < 4; i++) put_bit(1'b0, (erl && i == 3) ? ~inv : inv);
    for (int f = 0; f < nfr; f++) begin
      int len;
      len = total + ((f == extra_at) ? 1 : 0) - ((f == cut_at) ? 3 : 0);
      for (int p = 0; p < len; p++) begin
        logic d;
        bit act;
        int q;
        if (p < total) begin
          int k;
          logic [31:0] w;
          w = word_of(f, p / sb);
          k = (p % sb) - pd;
          if (k >= 0 && k < r) d = m ? w[r - 1 - k] : w[k];
          else d = 1'b1;
        end else d = 1'b0;
        q = erl ? p + 1 : p;
        if (q >= len) act = (f < nfr - 1);
        else act = (q < half);
        put_bit(d, act ? ~inv : inv);
      end
    end
    for (int i = 0; i < 3; i++) put_bit(1'b0, inv);
    repeat (8) @(negedge clk);
    int_a = (sa < ch) ? word_of(nfr - 1, sa) : 32'd0;
    int_b = (sbb < ch) ? word_of(nfr - 1, sbb) : 32'd0;
    chk(samp_a == int_a, t, "final word A", samp_a, int_a);
    chk(samp_b == int_b, t, "final word B", samp_b, int_b);
    chk(n_valid == exp_valid, "R11", "valid pulse count", 32'(n_valid), 32'(exp_valid));
    chk(n_err == exp_err, "R12", "sync error count", 32'(n_err), 32'(exp_err));
    chk(vq.size() == 0, "R11", "pending expected frames", 32'(vq.size()), 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: got %0d expected %0d", cyc, 200000);
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(samp_a == 0 && samp_b == 0, "R1", "words in reset", samp_a | samp_b, 32'd0);
    chk(samp_valid == 0 && sync_err == 0, "R1", "flags in reset",
        32'({samp_valid, sync_err}), 32'd0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(samp_valid == 0 && sync_err == 0 && samp_a == 0, "R1", "idle after reset",
        32'({samp_valid, sync_err}) | samp_a, 32'd0);
    // R5 R7 R4: two channels, one-bit-early active-low frame clock, MSB first
    run_scn("R5", 2, 32, 24, 0, 1, 0, 0, 1, 1, 0, 1, 3, -1, -1, 3, 0);
    // R2 R3 R7: eight slots, LSB first, frame on falling and data on rising edge
    run_scn("R3", 8, 16, 16, 0, 0, 1, 0, 0, 0, 2, 5, 3, -1, -1, 3, 0);
    // R6 R8: right-justified 20-bit word in a 32-bit slot
    run_scn("R8", 4, 32, 20, 12, 1, 0, 1, 0, 0, 0, 3, 3, -1, -1, 3, 0);
    // R4 R9 R6: single channel, inverted frame, slot B absent
    run_scn("R9", 1, 8, 5, 2, 0, 1, 1, 1, 0, 0, 1, 3, -1, -1, 3, 0);
    // R12: one frame stretched by a bit, one cut short by three bits
    run_scn("R12", 2, 16, 16, 0, 1, 0, 0, 0, 0, 0, 1, 5, 1, 3, 4, 2);
    // R10: 256 channels of two-bit slots
    run_scn("R10", 256, 2, 2, 0, 1, 0, 0, 0, 0, 200, 255, 2, -1, -1, 2, 0);
    checking = 0;
    finish_run();
  end

endmodule